// File: doc/BRIEF.md
# Programmable Per-Master Priority Arbiter

This block decides which of several bus masters may use a single shared slave port. Every master owns a small priority code held in an internal bank. Software changes a code through a one-entry-per-cycle write port. Code zero removes a master from contention. Any nonzero code ranks the master, and larger codes beat smaller ones.

The arbiter registers its decision. A grant shows up one clock after the requests that produced it and then stays fixed until the slave signals ready. Acceptance and re-arbitration happen on the same edge, so back-to-back transfers lose no cycle. The block does not multiplex data, does not decode addresses and does not implement any bus protocol. It only produces a one-hot grant, the index of the granted master and a valid flag.

Top module: `prio_arbiter`

## Requirements
- R1: After reset the grant vector, grant index and valid flag are all zero. Master 0 (parameter `RST_MASTER`) holds code 1 and every other master holds code 0, so only master 0 can win until the bank is rewritten.
- R2: A master whose code is 0 is never granted, even when it requests.
- R3: Among requesting masters with nonzero codes, the master with the largest code is granted. Code 1 is the lowest rank.
- R4: When requesting masters share the largest code, the one with the smaller index wins.
- R5: A written code larger than `N_MASTERS` (4 by default) is stored as `N_MASTERS`. For example, 7, 6 and 5 all rank equal to 4.
- R6: The grant is registered. Requests present before clock edge k yield a grant visible after edge k. `gnt_o` is one-hot or zero, bit i of `gnt_o` means master i, and `gnt_idx_o` is the index of the set bit.
- R7: While `gnt_valid_o` is high and `slv_ready_i` is low, the grant, index and valid flag keep their values whatever the requests or code writes do.
- R8: An edge with `gnt_valid_o` and `slv_ready_i` both high accepts the transfer and re-arbitrates on that same edge from the current requests.
- R9: When arbitration finds no requesting master with a nonzero code, the next grant is zero and `gnt_valid_o` is low.
- R10: A code write on edge k takes part in arbitration from edge k+1 onward. Edge k itself still uses the old code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_MASTERS | Request bit per master |
| code_we_i | input | 1 | Write strobe for the code bank |
| code_idx_i | input | $clog2(N_MASTERS) | Master whose code is written |
| code_val_i | input | PRIO_W | Code value to write (clamped) |
| slv_ready_i | input | 1 | Slave accepts the current grant |
| gnt_o | output | N_MASTERS | One-hot grant |
| gnt_idx_o | output | $clog2(N_MASTERS) | Index of the granted master |
| gnt_valid_o | output | 1 | A grant is present |

## Verification
The bench pits an over-range code against a legal top code on a lower-index master. A design that skipped clamping would hand the grant to the wrong master. Ties at equal codes catch a scan that resolves toward the higher index, and requesters parked at code zero catch an arbiter that treats zero as merely the lowest rank. Holding `slv_ready_i` low while a better requester arrives exposes a grant that is not held. A code write that lands while a grant is being accepted shows whether the new code leaks into arbitration one edge early.

// File: rtl/prio_arb_pkg.sv
// Shared types for the priority arbiter.
// Assumes: included first in compile order.
package prio_arb_pkg;

    // Occupancy of the grant register.
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_BUSY  = 1'b1
    } slot_state_e;

    // Code value that marks a master as excluded from arbitration.
    localparam int unsigned CODE_OFF = 0;

endpackage

// File: rtl/prio_code_bank.sv
// Per-master priority code storage.
// Does: stores one PRIO_W-bit code per master. A write larger than
// N_MASTERS is saturated to N_MASTERS before it is stored.
// Assumes: one write per cycle; an out-of-range index is dropped.
module prio_code_bank #(
    parameter int N_MASTERS  = 4,
    parameter int PRIO_W     = 3,
    parameter int RST_MASTER = 0,
    localparam int IDX_W     = $clog2(N_MASTERS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [PRIO_W-1:0]                val_i,
    output logic [N_MASTERS-1:0][PRIO_W-1:0] code_o
);
    localparam logic [PRIO_W-1:0] MAX_CODE = PRIO_W'(N_MASTERS);

    logic [PRIO_W-1:0] wr_code;

    // Saturate the incoming code to the highest legal rank.
    always_comb begin
        wr_code = (val_i > MAX_CODE) ? MAX_CODE : val_i;
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_slot
        localparam logic [PRIO_W-1:0] RST_VAL =
            (g == RST_MASTER) ? PRIO_W'(1) : PRIO_W'(prio_arb_pkg::CODE_OFF);

        // Hold this master's code; reset gives the boot master rank 1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_o[g] <= RST_VAL;
            end else if (we_i && (idx_i == IDX_W'(g))) begin
                code_o[g] <= wr_code;
            end
        end
    end
endmodule

// File: rtl/prio_winner_pick.sv
// Combinational winner selection.
// Does: among requesting masters with a nonzero code, finds the largest
// code. Ties go to the smaller index because the scan runs from the top
// index downward and accepts equal codes.
// Assumes: codes already saturated by the bank.
module prio_winner_pick #(
    parameter int N_MASTERS = 4,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0]             req_i,
    input  logic [N_MASTERS-1:0][PRIO_W-1:0] code_i,
    output logic                             win_valid_o,
    output logic [IDX_W-1:0]                 win_idx_o,
    output logic [N_MASTERS-1:0]             win_onehot_o
);
    logic [PRIO_W-1:0] best;

    // Scan high index to low; ">=" lets a lower index take a tie.
    always_comb begin
        best        = '0;
        win_idx_o   = '0;
        win_valid_o = 1'b0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req_i[i] && (code_i[i] != '0) && (code_i[i] >= best)) begin
                best        = code_i[i];
                win_idx_o   = IDX_W'(i);
                win_valid_o = 1'b1;
            end
        end
    end

    // Expand the winning index into a one-hot vector.
    always_comb begin
        win_onehot_o = '0;
        if (win_valid_o) begin
            win_onehot_o[win_idx_o] = 1'b1;
        end
    end
endmodule

// File: rtl/grant_hold_reg.sv
// Grant register with hold-until-accepted behaviour.
// Does: loads a new winner whenever the slot is empty or the slave
// accepts the current grant; otherwise keeps the grant unchanged.
// Assumes: slv_ready_i is only meaningful while a grant is present.
module grant_hold_reg #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W    = $clog2(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slv_ready_i,
    input  logic                 win_valid_i,
    input  logic [IDX_W-1:0]     win_idx_i,
    input  logic [N_MASTERS-1:0] win_onehot_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDX_W-1:0]     gnt_idx_o,
    output logic                 gnt_valid_o
);
    import prio_arb_pkg::*;

    slot_state_e state_q;
    logic        take_new;

    // A fresh decision is allowed when idle or on acceptance.
    always_comb begin
        take_new = (state_q == SLOT_EMPTY) || slv_ready_i;
    end

    // Load or hold the grant and its occupancy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SLOT_EMPTY;
            gnt_o     <= '0;
            gnt_idx_o <= '0;
        end else if (take_new) begin
            state_q   <= win_valid_i ? SLOT_BUSY : SLOT_EMPTY;
            gnt_o     <= win_onehot_i;
            gnt_idx_o <= win_idx_i;
        end
    end

    // Valid flag mirrors the occupancy state.
    always_comb begin
        gnt_valid_o = (state_q == SLOT_BUSY);
    end
endmodule

// File: rtl/prio_arbiter.sv
// Programmable per-master priority arbiter, top level.
// Does: code bank -> winner pick -> grant hold register.
// Assumes: N_MASTERS >= 2 and PRIO_W wide enough to hold N_MASTERS.
module prio_arbiter #(
    parameter int N_MASTERS  = 4,
    parameter int PRIO_W     = 3,
    parameter int RST_MASTER = 0,
    localparam int IDX_W     = $clog2(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 code_we_i,
    input  logic [IDX_W-1:0]     code_idx_i,
    input  logic [PRIO_W-1:0]    code_val_i,
    input  logic                 slv_ready_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDX_W-1:0]     gnt_idx_o,
    output logic                 gnt_valid_o
);
    logic [N_MASTERS-1:0][PRIO_W-1:0] code_q;
    logic                             win_valid;
    logic [IDX_W-1:0]                 win_idx;
    logic [N_MASTERS-1:0]             win_onehot;

    prio_code_bank #(
        .N_MASTERS (N_MASTERS),
        .PRIO_W    (PRIO_W),
        .RST_MASTER(RST_MASTER)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (code_we_i),
        .idx_i (code_idx_i),
        .val_i (code_val_i),
        .code_o(code_q)
    );

    prio_winner_pick #(
        .N_MASTERS(N_MASTERS),
        .PRIO_W   (PRIO_W)
    ) u_pick (
        .req_i       (req_i),
        .code_i      (code_q),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_onehot_o(win_onehot)
    );

    grant_hold_reg #(
        .N_MASTERS(N_MASTERS)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .slv_ready_i (slv_ready_i),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .win_onehot_i(win_onehot),
        .gnt_o       (gnt_o),
        .gnt_idx_o   (gnt_idx_o),
        .gnt_valid_o (gnt_valid_o)
    );
endmodule

// File: rtl/prio_arbiter_chk.sv
// Assertion checker for prio_arbiter, attached by bind below.
// Assumes: sees the top-level ports plus the stored code bank.
module prio_arbiter_chk #(
    parameter int N_MASTERS = 4,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = $clog2(N_MASTERS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [N_MASTERS-1:0]             req_i,
    input logic                             slv_ready_i,
    input logic [N_MASTERS-1:0]             gnt_o,
    input logic [IDX_W-1:0]                 gnt_idx_o,
    input logic                             gnt_valid_o,
    input logic [N_MASTERS-1:0][PRIO_W-1:0] code_q
);
    logic [N_MASTERS-1:0] elig;
    logic [N_MASTERS-1:0] elig_q;
    logic                 arb_q;

    // Masters that could legally win this cycle.
    always_comb begin
        for (int i = 0; i < N_MASTERS; i++) begin
            elig[i] = req_i[i] && (code_q[i] != '0);
        end
    end

    // Remember whether the last edge arbitrated, and over which masters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q  <= 1'b0;
            elig_q <= '0;
        end else begin
            arb_q  <= !gnt_valid_o || slv_ready_i;
            elig_q <= elig;
        end
    end

    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R6
    gnt_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> gnt_o[gnt_idx_o]);

    // R9
    gnt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid_o |-> (gnt_o == '0));

    // R2
    gnt_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q && gnt_valid_o) |-> ((gnt_o & ~elig_q) == '0));

    // R9
    no_eligible_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q && (elig_q == '0)) |-> !gnt_valid_o);

    // R7
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && !slv_ready_i) |=>
            (gnt_valid_o && $stable(gnt_o) && $stable(gnt_idx_o)));

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_code
        // R5
        code_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            code_q[g] <= PRIO_W'(N_MASTERS));
    end
endmodule

bind prio_arbiter prio_arbiter_chk #(
    .N_MASTERS(N_MASTERS),
    .PRIO_W   (PRIO_W)
) u_prio_arbiter_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .slv_ready_i(slv_ready_i),
    .gnt_o      (gnt_o),
    .gnt_idx_o  (gnt_idx_o),
    .gnt_valid_o(gnt_valid_o),
    .code_q     (code_q)
);

// File: tb/prio_arbiter_bench.sv
// Self-checking bench for prio_arbiter: vector table, then directed tests.
module prio_arbiter_bench;
    localparam int N  = 4;
    localparam int PW = 3;
    localparam int IW = 2;
    localparam int NV = 8;

    // Codes packed {m3,m2,m1,m0}, requests, expected grant.
    localparam logic [4*PW-1:0] V_CODE [NV] = '{
        {3'd1, 3'd2, 3'd3, 3'd4},   // R3
        {3'd1, 3'd2, 3'd3, 3'd4},   // R3
        {3'd1, 3'd0, 3'd0, 3'd0},   // R2
        {3'd2, 3'd2, 3'd2, 3'd2},   // R4
        {3'd4, 3'd4, 3'd1, 3'd0},   // R3
        {3'd0, 3'd7, 3'd4, 3'd0},   // R5 tie after clamp
        {3'd3, 3'd5, 3'd0, 3'd0},   // R5
        {3'd0, 3'd0, 3'd0, 3'd1}    // R9
    };
    localparam logic [N-1:0] V_REQ [NV] = '{
        4'b1111, 4'b1110, 4'b0111, 4'b1100,
        4'b1010, 4'b0110, 4'b1100, 4'b0000
    };
    localparam logic [N-1:0] V_GNT [NV] = '{
        4'b0001, 4'b0010, 4'b0000, 4'b0100,
        4'b1000, 4'b0010, 4'b0100, 4'b0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          we = 1'b0;
    logic [IW-1:0] widx = '0;
    logic [PW-1:0] wval = '0;
    logic          rdy = 1'b1;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gidx;
    logic          gval;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    prio_arbiter u_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .code_we_i(we), .code_idx_i(widx), .code_val_i(wval),
        .slv_ready_i(rdy), .gnt_o(gnt), .gnt_idx_o(gidx), .gnt_valid_o(gval)
    );

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare grant, index and valid against an expected one-hot grant.
    task automatic expect_gnt(input string tag, input logic [N-1:0] exp);
        logic [IW-1:0] eidx;
        eidx = '0;
        for (int i = 0; i < N; i++) if (exp[i]) eidx = IW'(i);
        n_checks++;
        if (gnt !== exp || gval !== (exp != '0) || gidx !== eidx) begin
            n_fail++;
            $display("FAIL %s: gnt=%b idx=%0d valid=%b expected gnt=%b idx=%0d valid=%b",
                     tag, gnt, gidx, gval, exp, eidx, exp != '0);
        end
    endtask

    task automatic write_code(input int idx, input logic [PW-1:0] val);
        we = 1'b1; widx = IW'(idx); wval = val;
        step();
        we = 1'b0;
    endtask

    task automatic load_codes(input logic [4*PW-1:0] c);
        for (int m = 0; m < N; m++) write_code(m, c[m*PW +: PW]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        expect_gnt("R1 reset outputs", 4'b0000);
        req = 4'b1110;
        step();
        expect_gnt("R1 non-boot masters locked out", 4'b0000);
        req = 4'b1111;
        expect_gnt("R6 no grant before edge", 4'b0000);
        step();
        expect_gnt("R1 boot master granted", 4'b0001);
        req = '0;
        step();

        // Vector table: R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            req = '0; rdy = 1'b1;
            load_codes(V_CODE[v]);
            req = V_REQ[v];
            step();
            expect_gnt($sformatf("R3/R4/R5 vector %0d", v), V_GNT[v]);
            req = '0;
            step();
        end

        // R7 hold, then R8 accept and re-arbitrate
        load_codes({3'd4, 3'd3, 3'd2, 3'd1});
        rdy = 1'b0; req = 4'b0001;
        step();
        expect_gnt("R7 first grant while not ready", 4'b0001);
        req = 4'b1000;
        step();
        expect_gnt("R7 held against higher requester", 4'b0001);
        write_code(0, 3'd0);
        expect_gnt("R7 held across code write", 4'b0001);
        rdy = 1'b1;
        step();
        expect_gnt("R8 re-arbitrate on acceptance", 4'b1000);
        req = '0;
        step();
        expect_gnt("R9 empty after acceptance", 4'b0000);

        // R10 write timing
        load_codes({3'd0, 3'd0, 3'd2, 3'd1});
        req = 4'b0011;
        step();
        expect_gnt("R10 setup", 4'b0010);
        we = 1'b1; widx = 2'd1; wval = 3'd0;
        step();
        we = 1'b0;
        expect_gnt("R10 old code on write edge", 4'b0010);
        step();
        expect_gnt("R10 new code next edge", 4'b0001);
        req = '0;
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule